// File: doc/BRIEF.md
# USB Slave-FIFO Bridge Master

This block sits in the FPGA and acts as the master of a USB bridge device whose endpoint buffers are exposed as a synchronous slave FIFO. The FPGA owns the interface clock. One shared 16-bit data bus carries traffic both ways, and the bridge's processor takes no part in moving the data. Two flows share the bus. Host commands arrive in the bridge's output endpoint and are read out word by word to a local command parser. Image words from a local buffer are written into the bridge's input endpoint for upload.

The block watches two status flags, both active-low. One shows that the output endpoint holds data; the other shows that the input endpoint is full. From these flags it chooses the endpoint address, the output enable, the read strobe, the write strobe and the bus drive direction. Pending host commands are served before image data. Every change of bus direction passes through one cycle in which the bus is released.

The data bus is split into an input path, an output path and a drive enable, so that the pad ring can build the tristate. A parameter selects the flag polarity. The default is active-low.

Top module: `sfb_bridge`

## Requirements
- R1: While reset is asserted, and when nothing is pending afterwards, bus_rd_n, bus_wr_n and bus_oe_n are high, and dq_drive, cmd_valid and img_take are low.
- R2: A read strobe (bus_rd_n low) occurs only when ep_out_empty_flag was 1 (not empty; the flag is active-low, 0 means empty) in the previous cycle. No word is read once the flag has gone to 0.
- R3: During a read strobe, ep_addr is 2'b00 and bus_oe_n is low. bus_oe_n was already low in the cycle before. bus_rd_n is low for exactly one cycle per word.
- R4: One cycle after each read strobe, cmd_valid is high for one cycle, and cmd_word equals the value dq_in carried during that strobe. Words reach the parser in bridge order.
- R5: During a write strobe (bus_wr_n low), ep_addr is 2'b10, dq_drive is high, dq_out equals img_word, and img_take is high. img_take is never high without a write strobe.
- R6: A write strobe occurs only in a cycle where ep_in_full_flag is 1 (not full; 0 means full). Writing stops in the same cycle the flag goes to 0 and resumes once space returns.
- R7: Host command reads take priority: no write strobe occurs in a cycle where ep_out_empty_flag is 1. When both flows are ready in the idle state, the read is served first.
- R8: dq_drive and bus_oe_n low never occur in the same cycle or in adjacent cycles. Every change of direction leaves one cycle with the bus released.
- R9: While the output endpoint stays non-empty, command words are delivered one every two cycles.
- R10: While image data is valid, space is available and no command is pending, one image word is written every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, also driven to the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_out_empty_flag | input | 1 | Output-endpoint empty flag (active-low by default) |
| ep_in_full_flag | input | 1 | Input-endpoint full flag (active-low by default) |
| ep_addr | output | 2 | Endpoint select toward the bridge |
| bus_oe_n | output | 1 | Bridge output enable, active-low |
| bus_rd_n | output | 1 | Read strobe, active-low |
| bus_wr_n | output | 1 | Write strobe, active-low |
| dq_in | input | 16 | Data bus as seen from the pad |
| dq_out | output | 16 | Data driven onto the bus |
| dq_drive | output | 1 | High when the FPGA drives the bus |
| cmd_word | output | 16 | Command word to the parser |
| cmd_valid | output | 1 | One-cycle valid for cmd_word |
| img_word | input | 16 | Next image word from the local buffer |
| img_valid | input | 1 | img_word is available |
| img_take | output | 1 | img_word is consumed this cycle |

## Verification
The bench builds the block with its defaults: a 16-bit bus, read endpoint 00, write endpoint 10 and active-low flags. Around it sits a bridge model whose input-endpoint capacity the bench sets at run time. A capacity of five is small enough that the full flag is reached within a single burst, so the stop and resume of writes can be seen. A capacity of eight, combined with random draining and random command arrivals, produces flag changes in the middle of write bursts and forces direction changes in both orders.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

   typedef enum logic [1:0] {
      SFB_IDLE   = 2'd0,
      SFB_RD_SEL = 2'd1,
      SFB_RD_STB = 2'd2,
      SFB_WR     = 2'd3
   } sfb_state_e;

endpackage

// File: rtl/sfb_flag_norm.sv
module sfb_flag_norm #(
   parameter bit FLAG_LOW_ACTIVE = 1'b1
) (
   input  logic out_empty_flag,
   input  logic in_full_flag,
   output logic cmd_avail,
   output logic in_space
);

   generate
      if (FLAG_LOW_ACTIVE) begin : g_low
         assign cmd_avail = out_empty_flag;
         assign in_space  = in_full_flag;
      end else begin : g_high
         assign cmd_avail = ~out_empty_flag;
         assign in_space  = ~in_full_flag;
      end
   endgenerate

endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
   import sfb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_avail,
   input  logic       in_space,
   input  logic       img_valid,
   output sfb_state_e state,
   output logic       wr_fire
);

   sfb_state_e state_nx;
   logic       wr_ready;

   assign wr_ready = img_valid & in_space & ~cmd_avail;
   assign wr_fire  = (state == SFB_WR) & wr_ready;

   always_comb begin
      state_nx = state;
      case (state)
         SFB_IDLE: begin
            if (cmd_avail)
               state_nx = SFB_RD_SEL;
            else if (img_valid && in_space)
               state_nx = SFB_WR;
         end
         SFB_RD_SEL: state_nx = cmd_avail ? SFB_RD_STB : SFB_IDLE;
         SFB_RD_STB: state_nx = SFB_RD_SEL;
         SFB_WR:     state_nx = wr_ready ? SFB_WR : SFB_IDLE;
         default:    state_nx = SFB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= SFB_IDLE;
      else
         state <= state_nx;
   end

   // R3
   stb_then_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SFB_RD_STB) |=> (state == SFB_RD_SEL));

   // R8
   no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SFB_WR) |=> (state == SFB_WR || state == SFB_IDLE));

endmodule

// File: rtl/sfb_rd_capture.sv
module sfb_rd_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] word,
   output logic              valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= strobe;
         if (strobe)
            word <= dq_in;
      end
   end

   // R4
   capture_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (valid && word == $past(dq_in)));

   // R4
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !valid);

endmodule

// File: rtl/sfb_wr_drive.sv
module sfb_wr_drive #(
   parameter int DATA_W = 16
) (
   input  logic              drive_en,
   input  logic              fire,
   input  logic [DATA_W-1:0] img_word,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive,
   output logic              wr_n,
   output logic              take
);

   assign dq_drive = drive_en;
   assign dq_out   = drive_en ? img_word : '0;
   assign wr_n     = ~(drive_en & fire);
   assign take     = drive_en & fire;

   // R5
   strobe_driven_chk: assert final (wr_n || (dq_drive && dq_out == img_word));

endmodule

// File: rtl/sfb_bridge.sv
module sfb_bridge
   import sfb_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int ADDR_W          = 2,
   parameter int RD_EP_ADDR      = 0,
   parameter int WR_EP_ADDR      = 2,
   parameter bit FLAG_LOW_ACTIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ep_out_empty_flag,
   input  logic              ep_in_full_flag,
   output logic [ADDR_W-1:0] ep_addr,
   output logic              bus_oe_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive,
   output logic [DATA_W-1:0] cmd_word,
   output logic              cmd_valid,
   input  logic [DATA_W-1:0] img_word,
   input  logic              img_valid,
   output logic              img_take
);

   localparam logic [ADDR_W-1:0] RD_CODE = ADDR_W'(RD_EP_ADDR);
   localparam logic [ADDR_W-1:0] WR_CODE = ADDR_W'(WR_EP_ADDR);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sfb_bridge: DATA_W must be positive");
      end
      if (RD_EP_ADDR == WR_EP_ADDR) begin : g_bad_addr
         $error("sfb_bridge: read and write endpoints must differ");
      end
      if (RD_EP_ADDR >= (1 << ADDR_W) || WR_EP_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("sfb_bridge: endpoint address does not fit ADDR_W");
      end
   endgenerate

   logic       cmd_avail;
   logic       in_space;
   logic       wr_fire;
   logic       rd_phase;
   logic       rd_strobe;
   logic       wr_phase;
   sfb_state_e state;

   sfb_flag_norm #(
      .FLAG_LOW_ACTIVE (FLAG_LOW_ACTIVE)
   ) u_flags (
      .out_empty_flag (ep_out_empty_flag),
      .in_full_flag   (ep_in_full_flag),
      .cmd_avail      (cmd_avail),
      .in_space       (in_space)
   );

   sfb_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_avail (cmd_avail),
      .in_space  (in_space),
      .img_valid (img_valid),
      .state     (state),
      .wr_fire   (wr_fire)
   );

   assign rd_phase  = (state == SFB_RD_SEL) || (state == SFB_RD_STB);
   assign rd_strobe = (state == SFB_RD_STB);
   assign wr_phase  = (state == SFB_WR);

   assign ep_addr  = wr_phase ? WR_CODE : RD_CODE;
   assign bus_oe_n = ~rd_phase;
   assign bus_rd_n = ~rd_strobe;

   sfb_rd_capture #(
      .DATA_W (DATA_W)
   ) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (rd_strobe),
      .dq_in  (dq_in),
      .word   (cmd_word),
      .valid  (cmd_valid)
   );

   sfb_wr_drive #(
      .DATA_W (DATA_W)
   ) u_drive (
      .drive_en (wr_phase),
      .fire     (wr_fire),
      .img_word (img_word),
      .dq_out   (dq_out),
      .dq_drive (dq_drive),
      .wr_n     (bus_wr_n),
      .take     (img_take)
   );

   // R2
   rd_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> $past(cmd_avail));

   // R3
   rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (ep_addr == RD_CODE && !bus_oe_n && $past(!bus_oe_n)));

   // R3
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |=> bus_rd_n);

   // R5
   wr_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> (dq_drive && ep_addr == WR_CODE && img_take && dq_out == img_word));

   // R5
   take_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      img_take |-> (!bus_wr_n && img_valid));

   // R6
   wr_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> in_space);

   // R7
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !cmd_avail);

   // R8
   drive_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |=> bus_oe_n);

   // R8
   oe_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_n |=> !dq_drive);

   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dq_drive && !bus_oe_n));

endmodule

// File: tb/sfb_bridge_test.sv
`timescale 1ns/1ps
module sfb_bridge_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // bridge and source model state
   int   out_push = 0, out_pop = 0, in_fill = 0, in_cap = 64, img_idx = 0;
   bit   drain_en = 1'b0;
   logic img_valid = 1'b0;

   logic        ep_out_empty_flag, ep_in_full_flag;
   logic [1:0]  ep_addr;
   logic        bus_oe_n, bus_rd_n, bus_wr_n, dq_drive, cmd_valid, img_take;
   logic [15:0] dq_in, dq_out, cmd_word, img_word;

   function automatic logic [15:0] exp_cmd_val(int n);
      return 16'((n * 12569) + 257);
   endfunction

   function automatic logic [15:0] exp_img_val(int n);
      return 16'((n * 40503) ^ 23130);
   endfunction

   assign ep_out_empty_flag = (out_push > out_pop);
   assign ep_in_full_flag   = (in_fill < in_cap);
   assign dq_in             = !bus_oe_n ? exp_cmd_val(out_pop) : 16'hDEAD;
   assign img_word          = exp_img_val(img_idx);

   sfb_bridge uut (
      .clk               (clk),
      .rst_n             (rst_n),
      .ep_out_empty_flag (ep_out_empty_flag),
      .ep_in_full_flag   (ep_in_full_flag),
      .ep_addr           (ep_addr),
      .bus_oe_n          (bus_oe_n),
      .bus_rd_n          (bus_rd_n),
      .bus_wr_n          (bus_wr_n),
      .dq_in             (dq_in),
      .dq_out            (dq_out),
      .dq_drive          (dq_drive),
      .cmd_word          (cmd_word),
      .cmd_valid         (cmd_valid),
      .img_word          (img_word),
      .img_valid         (img_valid),
      .img_take          (img_take)
   );

   int checks = 0, errors = 0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: samples mid-cycle
   bit s_rd = 0, s_wr = 0, s_take = 0;
   bit p_oe_low = 0, p_drive = 0, p_rd = 0;
   int cyc = 0, exp_cmd = 0, wr_total = 0;
   int cmdv_n = 0, cmdv_first = 0, cmdv_last = 0;
   int wr_cnt = 0, wr_first = 0, wr_last = 0;
   int first_kind = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         s_rd   = !bus_rd_n;
         s_wr   = !bus_wr_n;
         s_take = img_take;
         if (s_rd) begin
            chk(ep_out_empty_flag == 1'b1, "R2", "read while empty", 32'(ep_out_empty_flag), 1);
            chk(ep_addr == 2'b00 && !bus_oe_n, "R3", "read addr/oe", 32'({ep_addr, bus_oe_n}), 32'h0);
            chk(p_oe_low, "R3", "oe not low before strobe", 32'(p_oe_low), 1);
            chk(!p_rd, "R3", "strobe longer than one cycle", 32'(p_rd), 0);
            if (first_kind == 0) first_kind = 1;
         end
         if (s_wr) begin
            chk(ep_addr == 2'b10, "R5", "write addr", 32'(ep_addr), 32'h2);
            chk(dq_drive, "R5", "bus not driven", 32'(dq_drive), 1);
            chk(dq_out == exp_img_val(img_idx), "R5", "write data", 32'(dq_out), 32'(exp_img_val(img_idx)));
            chk(s_take, "R5", "no take on write", 32'(s_take), 1);
            chk(ep_in_full_flag == 1'b1, "R6", "write while full", 32'(ep_in_full_flag), 1);
            chk(ep_out_empty_flag == 1'b0, "R7", "write with command pending", 32'(ep_out_empty_flag), 0);
            wr_total++;
            if (wr_cnt == 0) wr_first = cyc;
            wr_last = cyc;
            wr_cnt++;
            if (first_kind == 0) first_kind = 2;
         end else if (s_take) begin
            chk(1'b0, "R5", "take without strobe", 1, 0);
         end
         if (cmd_valid) begin
            chk(cmd_word == exp_cmd_val(exp_cmd), "R4", "command word", 32'(cmd_word), 32'(exp_cmd_val(exp_cmd)));
            chk(p_rd, "R4", "valid without prior strobe", 32'(p_rd), 1);
            exp_cmd++;
            if (cmdv_n == 0) cmdv_first = cyc;
            cmdv_last = cyc;
            cmdv_n++;
         end
         if (dq_drive || !bus_oe_n)
            chk(!(dq_drive && p_oe_low) && !(!bus_oe_n && p_drive) && !(dq_drive && !bus_oe_n),
                "R8", "no turnaround", 32'({dq_drive, bus_oe_n, p_drive, p_oe_low}), 32'h0);
         p_oe_low = !bus_oe_n;
         p_drive  = dq_drive;
         p_rd     = s_rd;
      end else begin
         s_rd = 0; s_wr = 0; s_take = 0;
      end
   end

   // bridge model: effects of the strobes sampled mid-cycle
   always @(posedge clk) begin
      if (s_rd)   out_pop <= out_pop + 1;
      if (s_take) img_idx <= img_idx + 1;
      in_fill <= in_fill + (s_wr ? 1 : 0) - ((drain_en && in_fill > 0) ? 1 : 0);
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      int seed_val;
      int snap;
      seed_val = $urandom(32'h1F2E3D4C);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_rd_n && bus_wr_n && bus_oe_n, "R1", "strobes in reset", 32'({bus_rd_n, bus_wr_n, bus_oe_n}), 32'h7);
      chk(!dq_drive && !cmd_valid && !img_take, "R1", "drive/valid/take in reset", 32'({dq_drive, cmd_valid, img_take}), 0);
      rst_n = 1'b1;
      step(3);
      chk(bus_rd_n && bus_wr_n && bus_oe_n && !dq_drive, "R1", "idle after reset", 32'({bus_rd_n, bus_wr_n, bus_oe_n, dq_drive}), 32'he);

      // R9 read burst
      cmdv_n = 0;
      out_push += 4;
      step(14);
      chk(cmdv_n == 4, "R9", "burst word count", 32'(cmdv_n), 4);
      chk(cmdv_last - cmdv_first == 6, "R9", "burst spacing", 32'(cmdv_last - cmdv_first), 6);
      chk(out_pop == 4, "R2", "reads stop at empty", 32'(out_pop), 4);

      // R10 and R6 write burst into a small endpoint
      in_cap = 5;
      wr_cnt = 0;
      img_valid = 1'b1;
      step(12);
      chk(wr_cnt == 5, "R6", "writes stop at full", 32'(wr_cnt), 5);
      chk(wr_last - wr_first == 4, "R10", "one word per cycle", 32'(wr_last - wr_first), 4);
      chk(bus_wr_n == 1'b1, "R6", "no strobe while full", 32'(bus_wr_n), 1);
      drain_en = 1'b1;
      step(20);
      chk(wr_cnt > 5, "R6", "writes resume with space", 32'(wr_cnt), 6);
      img_valid = 1'b0;
      step(4);

      // R7 both ready in idle: read first
      in_cap = 64;
      first_kind = 0;
      img_valid = 1'b1;
      out_push += 1;
      step(10);
      chk(first_kind == 1, "R7", "read served first", 32'(first_kind), 1);

      // R7 command arriving inside a write burst
      snap = wr_total;
      step(2);
      out_push += 2;
      step(14);
      chk(exp_cmd == out_push, "R7", "commands served during upload", 32'(exp_cmd), 32'(out_push));
      chk(wr_total > snap, "R10", "upload continues", 32'(wr_total), 32'(snap + 1));

      // random phase
      in_cap = 8;
      for (int i = 0; i < 4000; i++) begin
         step(1);
         img_valid = ($urandom % 4) != 0;
         if ($urandom % 20 == 0) out_push += 1 + int'($urandom % 3);
         drain_en = ($urandom % 3) != 0;
      end
      img_valid = 1'b0;
      drain_en = 1'b1;
      step(60);
      chk(exp_cmd == out_push, "R4", "all commands delivered", 32'(exp_cmd), 32'(out_push));
      chk(out_pop == out_push, "R2", "reads match pushes", 32'(out_pop), 32'(out_push));
      chk(wr_total == img_idx, "R5", "takes match writes", 32'(wr_total), 32'(img_idx));
      chk(bus_rd_n && bus_wr_n && bus_oe_n && !dq_drive, "R1", "idle at end", 32'({bus_rd_n, bus_wr_n, bus_oe_n, dq_drive}), 32'he);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

endmodule